// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

The block holds three independent 16-bit down counters behind an 8-bit register bus. Each channel has a count port of its own, plus a count-enable input and an output pin. A shared control port takes a control byte that picks the channel, how count bytes move across the bus, the counting mode, and whether the channel counts in binary or in four BCD digits. Software writes a control byte, writes the count one byte at a time, and the channel starts on its next enabled clock.

The counter can be read while it runs. A read returns the live count. A latch command through the control port freezes a snapshot of the count, and the channel keeps counting underneath it. The snapshot is released once every byte of it has been read. Three output behaviours are supported: a level that rises at terminal count, a periodic one-clock low pulse, and a square wave.

Top module: `pit_timer3`

## Requirements
- R1: Addresses 0, 1 and 2 are the count ports of channels 0, 1 and 2, and address 3 is the control port. Control bits 7:6 pick the channel. A control write with bits 7:6 = 11 changes nothing. A read of address 3 returns 0.
- R2: Control bit 0 = 1 selects BCD counting. Control bits 3:1 = 010 select the rate mode and 011 selects the square mode. Every other value of bits 3:1, including 001, 100 and 101, behaves as the terminal-count mode.
- R3: Control bits 5:4 = 01 select LSB-only access, and a written byte loads count {8'h00, byte}. Bits 5:4 = 10 select MSB-only access, and a written byte loads {byte, 8'h00}. Reads in these access types return only that byte.
- R4: Control bits 5:4 = 11 select word access: LSB first, then MSB, for both writes and reads. Any control write to the channel resets the byte order to the LSB. A count takes effect on the first enabled clock after its final byte is written, and that clock only loads the count.
- R5: In the terminal-count mode the output goes low on the control write and on the final count byte. It goes high on the N-th enabled clock after the loading clock, and it stays high while the count wraps.
- R6: In the rate mode, with count N of at least 2, the output is high after loading. It is low for one enabled clock every N enabled clocks, and each low clock coincides with a reload of N.
- R7: In the square mode the output is high after loading. It inverts every ceil(N/2) enabled clocks.
- R8: In BCD counting each decrement treats the count as four decimal digits, so 0x1000 steps to 0x0999.
- R9: A count of 0 means the largest count. The first decrement gives 0xFFFF in binary and 0x9999 in BCD.
- R10: A channel's count and output change only on clocks where its count-enable input is high, or through bus writes addressed to that channel.
- R11: Control bits 5:4 = 00 latch the channel's count. Reads then return the frozen value while counting continues. The latch is released after its last byte is read, and later reads return the live count.
- R12: A latch command issued while an earlier snapshot is still unread is ignored.
- R13: A read of a count port returns the selected byte on rdata one clock later. rdata is 0 in any clock that follows no read. Reads never disturb counting.
- R14: After reset every output pin is low, rdata is 0, and every count reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 2 | Register address: 0..2 count ports, 3 control |
| wdata | input | 8 | Write data |
| cnt_en | input | 3 | Per-channel count enable |
| rdata | output | 8 | Registered read data |
| tmr_out | output | 3 | Per-channel timer output |

## Verification
Random counts are run through all three modes, and the bench samples the output on every enabled clock. A design that loads one clock late, or that reloads one count short, shifts every edge and fails at once. BCD and binary wrap are checked from random start values. That exposes a digit borrow that skips a nine, or a zero count that is not read as maximum. The latch tests keep the counter running between the latch command and the reads, and they issue a second latch before the first is drained, so a snapshot that tracks the live count or gets overwritten returns the wrong value. Stale MSB data after an LSB-only load, a byte toggle that survives a new control word, and a channel-select 11 write that reaches a channel each show up as a wrong count or a flipped output.

// File: rtl/pit_pkg.sv
package pit_pkg;
  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LSB   = 2'b01,
    ACC_MSB   = 2'b10,
    ACC_WORD  = 2'b11
  } pit_acc_e;

  typedef enum logic [1:0] {
    MD_TERM   = 2'd0,
    MD_RATE   = 2'd1,
    MD_SQUARE = 2'd2
  } pit_mode_e;

  // Modes outside rate/square collapse onto terminal-count behaviour.
  function automatic pit_mode_e decode_mode(input logic [2:0] f);
    case (f)
      3'b010:  return MD_RATE;
      3'b011:  return MD_SQUARE;
      default: return MD_TERM;
    endcase
  endfunction
endpackage

// File: rtl/pit_dec_step.sv
module pit_dec_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] val,
  input  logic         bcd,
  output logic [W-1:0] nxt
);
  localparam int DIGITS = W / 4;

  logic [DIGITS-1:0] brw;
  logic [W-1:0]      bcd_nxt;

  assign brw[0] = 1'b1;

  for (genvar d = 0; d < DIGITS; d++) begin : g_dig
    logic [3:0] dig;
    assign dig = val[4*d +: 4];
    assign bcd_nxt[4*d +: 4] = !brw[d] ? dig : ((dig == 4'd0) ? 4'd9 : dig - 4'd1);
    if (d + 1 < DIGITS) begin : g_brw
      assign brw[d+1] = brw[d] && (dig == 4'd0);
    end
  end

  assign nxt = bcd ? bcd_nxt : (val - W'(1));
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              ctl_we,
  input  logic              latch_req,
  input  logic              dat_we,
  input  logic              dat_re,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              tmr_out,
  output logic              latched
);
  localparam int CW = 2 * BYTE_W;

  pit_mode_e         mode_q;
  pit_acc_e          acc_q;
  logic              bcd_q;
  logic [CW-1:0]     reload_q, cnt_q, hold_q;
  logic              lat_q, wr_hi_q, rd_hi_q, pend_q, arm_q, out_q;
  logic [CW-1:0]     dec1, dec2, src;
  logic              rd_hi, wr_last;
  pit_mode_e         new_mode;

  pit_dec_step #(.W(CW)) u_dec1 (.val(cnt_q), .bcd(bcd_q), .nxt(dec1));
  pit_dec_step #(.W(CW)) u_dec2 (.val(dec1),  .bcd(bcd_q), .nxt(dec2));

  assign new_mode = decode_mode(wdata[3:1]);
  assign src      = lat_q ? hold_q : cnt_q;
  assign rd_hi    = (acc_q == ACC_MSB) || ((acc_q == ACC_WORD) && rd_hi_q);
  assign rd_byte  = rd_hi ? src[CW-1:BYTE_W] : src[BYTE_W-1:0];
  assign wr_last  = dat_we && ((acc_q != ACC_WORD) || wr_hi_q);
  assign tmr_out  = out_q;
  assign latched  = lat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MD_TERM;
      acc_q    <= ACC_WORD;
      bcd_q    <= 1'b0;
      reload_q <= '0;
      cnt_q    <= '0;
      hold_q   <= '0;
      lat_q    <= 1'b0;
      wr_hi_q  <= 1'b0;
      rd_hi_q  <= 1'b0;
      pend_q   <= 1'b0;
      arm_q    <= 1'b0;
      out_q    <= 1'b0;
    end else if (ctl_we) begin
      mode_q  <= new_mode;
      acc_q   <= pit_acc_e'(wdata[5:4]);
      bcd_q   <= wdata[0];
      wr_hi_q <= 1'b0;
      rd_hi_q <= 1'b0;
      lat_q   <= 1'b0;
      pend_q  <= 1'b0;
      arm_q   <= 1'b0;
      out_q   <= (new_mode != MD_TERM);
    end else begin
      // counting on enabled clocks
      if (en) begin
        if (pend_q) begin
          cnt_q  <= reload_q;
          pend_q <= 1'b0;
          arm_q  <= 1'b1;
          if (mode_q != MD_TERM) out_q <= 1'b1;
        end else if (arm_q) begin
          case (mode_q)
            MD_RATE: begin
              if (cnt_q == CW'(1)) begin
                cnt_q <= reload_q;
                out_q <= 1'b0;
              end else begin
                cnt_q <= dec1;
                out_q <= 1'b1;
              end
            end
            MD_SQUARE: begin
              if (cnt_q == CW'(1) || cnt_q == CW'(2)) begin
                cnt_q <= reload_q;
                out_q <= !out_q;
              end else begin
                cnt_q <= dec2;
              end
            end
            default: begin
              cnt_q <= dec1;
              if (cnt_q == CW'(1)) out_q <= 1'b1;
            end
          endcase
        end
      end
      // snapshot
      if (latch_req && !lat_q) begin
        hold_q  <= cnt_q;
        lat_q   <= 1'b1;
        rd_hi_q <= 1'b0;
      end
      // reads
      if (dat_re) begin
        if (acc_q == ACC_WORD) rd_hi_q <= !rd_hi_q;
        if (lat_q && ((acc_q != ACC_WORD) || rd_hi_q)) lat_q <= 1'b0;
      end
      // count writes
      if (dat_we) begin
        case (acc_q)
          ACC_LSB: reload_q <= {{BYTE_W{1'b0}}, wdata};
          ACC_MSB: reload_q <= {wdata, {BYTE_W{1'b0}}};
          default: begin
            if (!wr_hi_q) reload_q[BYTE_W-1:0] <= wdata;
            else          reload_q[CW-1:BYTE_W] <= wdata;
            wr_hi_q <= !wr_hi_q;
          end
        endcase
      end
      if (wr_last) begin
        pend_q <= 1'b1;
        if (mode_q == MD_TERM) out_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pit_timer3.sv
module pit_timer3 #(
  parameter int  NUM_CH = 3,
  parameter int  BYTE_W = 8,
  localparam int ADDR_W = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [NUM_CH-1:0] cnt_en,
  output logic [BYTE_W-1:0] rdata,
  output logic [NUM_CH-1:0] tmr_out
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_CH);

  logic [BYTE_W-1:0] rd_byte [NUM_CH];
  logic [NUM_CH-1:0] lat_vec;
  logic [1:0]        sel;
  logic              ctl_hit, is_latch;
  logic [BYTE_W-1:0] sel_byte;
  logic              rd_cnt;

  assign sel      = wdata[BYTE_W-1 -: 2];
  assign ctl_hit  = wr_en && (addr == CTRL_ADDR);
  assign is_latch = (wdata[5:4] == 2'b00);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic hit;
    assign hit = ctl_hit && (sel == 2'(i));
    pit_channel #(.BYTE_W(BYTE_W)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .en        (cnt_en[i]),
      .ctl_we    (hit && !is_latch),
      .latch_req (hit && is_latch),
      .dat_we    (wr_en && (addr == ADDR_W'(i))),
      .dat_re    (rd_en && (addr == ADDR_W'(i))),
      .wdata     (wdata),
      .rd_byte   (rd_byte[i]),
      .tmr_out   (tmr_out[i]),
      .latched   (lat_vec[i])
    );
  end

  always_comb begin
    sel_byte = '0;
    rd_cnt   = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == ADDR_W'(i)) begin
        sel_byte = rd_byte[i];
        rd_cnt   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  rdata <= '0;
    else if (rd_en && rd_cnt) rdata <= sel_byte;
    else                      rdata <= '0;
  end
endmodule

// File: rtl/pit_timer3_chk.sv
module pit_timer3_chk #(
  parameter int NUM_CH = 3,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [BYTE_W-1:0] wdata,
  input logic [NUM_CH-1:0] cnt_en,
  input logic [BYTE_W-1:0] rdata,
  input logic [NUM_CH-1:0] tmr_out,
  input logic [NUM_CH-1:0] latched
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_CH);

  // R10: without a write, an output moves only on its enabled clocks
  p_out_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> ((tmr_out ^ $past(tmr_out)) & ~$past(cnt_en)) == '0);

  // R1: a control write with channel select 11 touches no output
  p_sel3_ignored_r1: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && addr == CTRL_ADDR && wdata[BYTE_W-1 -: 2] == 2'b11)
      |-> ((tmr_out ^ $past(tmr_out)) & ~$past(cnt_en)) == '0);

  // R13: rdata is zero after any clock without a count-port read
  p_rdata_idle_r13: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en && addr != CTRL_ADDR) |-> rdata == '0);

  // R12: a snapshot only starts from a latch command
  p_latch_src_r12: assert property (@(posedge clk) disable iff (rst)
    ((latched & ~$past(latched)) != '0)
      |-> $past(wr_en && addr == CTRL_ADDR && wdata[5:4] == 2'b00));

  // R11: at most one channel begins a snapshot per clock
  p_latch_one_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(latched & ~$past(latched)));
endmodule

bind pit_timer3 pit_timer3_chk #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .addr    (addr),
  .wdata   (wdata),
  .cnt_en  (cnt_en),
  .rdata   (rdata),
  .tmr_out (tmr_out),
  .latched (lat_vec)
);

// File: tb/pit_timer3_test.sv
module pit_timer3_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [2:0] cnt_en = '0;
  logic [7:0] rdata;
  logic [2:0] tmr_out;
  int nchk = 0, nfail = 0;

  always #5 clk = ~clk;

  pit_timer3 uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .cnt_en(cnt_en), .rdata(rdata), .tmr_out(tmr_out)
  );

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  task automatic rd_word(input logic [1:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(a, lo); rd(a, hi);
    v = {hi, lo};
  endtask

  task automatic step(input int ch, input int k);
    for (int j = 0; j < k; j++) begin
      cnt_en[ch] = 1'b1;
      @(negedge clk);
    end
    cnt_en[ch] = 1'b0;
  endtask

  task automatic load(input logic [1:0] ch, input logic [7:0] ctl, input logic [15:0] n);
    wr(2'd3, ctl); wr(ch, n[7:0]); wr(ch, n[15:8]);
  endtask

  function automatic int bcd2int(input logic [15:0] b);
    return b[15:12]*1000 + b[11:8]*100 + b[7:4]*10 + b[3:0];
  endfunction

  function automatic logic [15:0] int2bcd(input int v);
    return {4'(v/1000), 4'((v/100)%10), 4'((v/10)%10), 4'(v%10)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] w, w2;
    int seed, errs;
    seed = $urandom(32'h5EED1);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R14 reset state
    check("R14 outputs", tmr_out, 0);
    check("R14 rdata", rdata, 0);
    rd_word(2'd0, w);
    check("R14 count", w, 0);

    // R4/R5 word load, terminal count
    load(2'd0, 8'h30, 16'd5);
    check("R5 low after load", tmr_out[0], 0);
    step(0, 5);
    check("R5 still low", tmr_out[0], 0);
    step(0, 1);
    check("R5 high at terminal", tmr_out[0], 1);
    rd_word(2'd0, w);
    check("R5 count zero", w, 0);
    step(0, 3);
    check("R5 stays high", tmr_out[0], 1);
    rd_word(2'd0, w);
    check("R9 binary wrap", w, 16'hFFFD);

    // R4 toggle reset by control write
    wr(2'd3, 8'h30);
    check("R5 low on control", tmr_out[0], 0);
    wr(2'd0, 8'h99);
    wr(2'd3, 8'h30);
    wr(2'd0, 8'h07); wr(2'd0, 8'h00);
    step(0, 1);
    rd_word(2'd0, w);
    check("R4 toggle reset", w, 16'h0007);

    // R3 single-byte access
    wr(2'd3, 8'h50); wr(2'd1, 8'h34);
    step(1, 1);
    rd(2'd1, b);
    check("R3 LSB", b, 8'h34);
    wr(2'd3, 8'h60); wr(2'd1, 8'h12);
    step(1, 2);
    rd(2'd1, b);
    check("R3 MSB clears LSB", b, 8'h11);
    @(negedge clk);
    check("R13 idle rdata", rdata, 0);

    // R8 BCD
    load(2'd2, 8'hB1, 16'h1000);
    step(2, 2);
    rd_word(2'd2, w);
    check("R8 BCD borrow", w, 16'h0999);
    for (int t = 0; t < 6; t++) begin
      int v, k;
      v = 1 + ($urandom % 9999);
      k = 1 + ($urandom % 200);
      load(2'd2, 8'hB1, int2bcd(v));
      step(2, 1 + k);
      rd_word(2'd2, w);
      check("R8 BCD random", w, int2bcd((v - k + 10000) % 10000));
    end
    for (int t = 0; t < 4; t++) begin
      logic [15:0] v;
      int k;
      v = 16'($urandom);
      k = 1 + ($urandom % 300);
      load(2'd0, 8'h30, v);
      step(0, 1 + k);
      rd_word(2'd0, w);
      check("R13 binary random", w, 16'(v - 16'(k)));
    end

    // R9 zero means max
    load(2'd2, 8'hB1, 16'h0000);
    step(2, 2);
    rd_word(2'd2, w);
    check("R9 BCD zero", w, 16'h9999);
    load(2'd2, 8'hB0, 16'h0000);
    step(2, 2);
    rd_word(2'd2, w);
    check("R9 binary zero", w, 16'hFFFF);

    // R10 disabled channel holds
    step(0, 10);
    rd_word(2'd2, w);
    check("R10 hold", w, 16'hFFFF);

    // R11 latch while running, R12 second latch ignored
    load(2'd0, 8'h30, 16'h1000);
    step(0, 17);
    wr(2'd3, 8'h00);
    step(0, 50);
    rd_word(2'd0, w);
    check("R11 frozen", w, 16'h0FF0);
    rd_word(2'd0, w);
    check("R11 released", w, 16'h0FBE);
    wr(2'd3, 8'h00);
    step(0, 5);
    wr(2'd3, 8'h00);
    step(0, 5);
    rd_word(2'd0, w);
    check("R12 first latch kept", w, 16'h0FBE);
    rd_word(2'd0, w2);
    check("R13 live after latch", w2, 16'h0FB4);
    rd(2'd3, b);
    check("R1 control read zero", b, 0);

    // R6 rate mode
    for (int t = 0; t < 4; t++) begin
      int n;
      n = 2 + ($urandom % 19);
      load(2'd1, 8'h74, 16'(n));
      errs = 0;
      cnt_en[1] = 1'b1;
      for (int k = 1; k <= 3 * n + 2; k++) begin
        @(negedge clk);
        if (tmr_out[1] != !(k > 1 && (k - 1) % n == 0)) errs++;
      end
      cnt_en[1] = 1'b0;
      check("R6 rate pattern", errs, 0);
    end

    // R7 square mode
    for (int t = 0; t < 4; t++) begin
      int n, h;
      n = 3 + ($urandom % 18);
      h = (n + 1) / 2;
      load(2'd0, 8'h36, 16'(n));
      errs = 0;
      cnt_en[0] = 1'b1;
      for (int k = 1; k <= 4 * n; k++) begin
        @(negedge clk);
        if (tmr_out[0] != (((k - 1) / h) % 2 == 0)) errs++;
      end
      cnt_en[0] = 1'b0;
      check("R7 square pattern", errs, 0);
    end

    // R5 random terminal count
    for (int t = 0; t < 4; t++) begin
      int n;
      n = 2 + ($urandom % 199);
      load(2'd1, 8'h70, 16'(n));
      errs = 0;
      cnt_en[1] = 1'b1;
      for (int k = 1; k <= n + 3; k++) begin
        @(negedge clk);
        if (tmr_out[1] != (k >= n + 1)) errs++;
      end
      cnt_en[1] = 1'b0;
      check("R5 terminal timing", errs, 0);
    end

    // R2 one-shot code acts as terminal count
    load(2'd1, 8'h72, 16'd3);
    check("R2 mode1 low", tmr_out[1], 0);
    step(1, 3);
    check("R2 mode1 before", tmr_out[1], 0);
    step(1, 1);
    check("R2 mode1 terminal", tmr_out[1], 1);

    // R1 select 11 ignored
    load(2'd2, 8'hB4, 16'd5);
    step(2, 2);
    wr(2'd3, 8'hF0);
    wr(2'd3, 8'hC0);
    check("R1 sel3 out", tmr_out[2], 1);
    rd_word(2'd2, w);
    check("R1 sel3 count", w, 16'd4);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule